// File: doc/BRIEF.md
# Codec Reset and Power-Down Sequencer

This block orders the entry into and exit from reset for the digital side of a multi-channel audio converter. A software run bit asks for normal operation when it is high and for power-down when it is low. The block follows that bit with a delayed internal reset and gates the ADC and DAC digital blocks from it. It holds the serial data output low and forces the ADC output word to zero while the converter is down or still initialising. Two zero-detect flags get their own release timing. Configuration registers outside the block keep their contents across a software power-down; only the hardware reset input clears this block.

All delays are counted in frame periods. A frame is a one-cycle strobe on the master clock. When the frame clocks stop, the pending delays freeze, so the block cannot leave reset until framing resumes. A flip of the run bit cancels a delay that is still counting, and the count starts again from zero in the new direction. After the internal reset lifts, the ADC runs a fixed initialisation of several hundred frames and sends zeros until it ends. The ready output is high only in normal operation with that initialisation complete. The block carries no streamed data, so all of its pins are plain level controls with no valid/ready handshake.

Top module: `codec_rst_seq`

## Requirements
- R1: While `rst_n` is low, and at the first sampling point after it, `int_rst`=1, `adc_en`=`dac_en`=0, `sdo_force_low`=1, `adc_zero`=1, every `zflag` bit is 1 and `ready`=0.
- R2: With `run_req` low and `int_rst` low, `int_rst` rises on the clock edge that samples the 5th `frame_tick` (ENTER_FRAMES) and not before.
- R3: With `run_req` high and `int_rst` high, `int_rst` falls on the clock edge that samples the 2nd `frame_tick` (LEAVE_FRAMES) and not before.
- R4: `adc_en` and `dac_en` are 1 exactly when `int_rst` is 0, and `sdo_force_low` is 1 exactly when `int_rst` is 1.
- R5: After `int_rst` falls, `adc_zero` stays 1 until the edge that samples the 516th `frame_tick` (INIT_FRAMES) counted from the edge after the fall. It is 0 from then on while `int_rst` stays low. `adc_zero` is 1 whenever `int_rst` is 1.
- R6: Every `zflag` bit is 1 one clock after `run_req` is sampled low.
- R7: With `run_req` high, the `zflag` bits fall on the edge that samples the 7th `frame_tick` (FLAG_FRAMES) after `run_req` went high.
- R8: If `run_req` changes back before an entry or release delay completes, `int_rst` does not change, and a later request counts its full delay from zero.
- R9: Without `frame_tick` pulses, `int_rst` and `zflag` hold their values however long `run_req` is held.
- R10: `ready` is 1 exactly when `int_rst` is 0 and the ADC initialisation of R5 has completed.
- R11: Re-entering reset during the ADC initialisation abandons it. The next release starts a full new INIT_FRAMES count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| frame_tick | input | 1 | One-cycle strobe per frame period |
| run_req | input | 1 | Software control: 1 = run, 0 = power down |
| int_rst | output | 1 | Delayed internal reset, active high |
| adc_en | output | 1 | ADC digital block enable |
| dac_en | output | 1 | DAC digital block enable |
| sdo_force_low | output | 1 | Hold the serial data output low |
| adc_zero | output | 1 | Force the ADC output word to all zeros |
| zflag | output | NFLAG | Zero-detect flags |
| ready | output | 1 | Normal operation with ADC initialisation complete |

## Verification
The bench targets the counting edges. A design off by one frame on entry, release or flag timing flips a vector one table row early or late. A design that does not clear its counter on a cancelled request enters reset after only the remainder of the first count. A design that keeps the initialisation progress across an aborted run releases `adc_zero` too early on the second release. A design that counts master clocks instead of frames leaves reset during the stopped-frame test.

// File: rtl/codec_rst_pkg.sv
package codec_rst_pkg;

  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_ENTER = 2'd1,
    PH_DOWN  = 2'd2,
    PH_LEAVE = 2'd3
  } phase_t;

  // width of a counter that holds 0 .. n-1
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/crs_reset_delay.sv
module crs_reset_delay
  import codec_rst_pkg::*;
#(
  parameter int unsigned ENTER_FRAMES = 5,
  parameter int unsigned LEAVE_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic int_rst
);
  localparam int unsigned MAXF = (ENTER_FRAMES > LEAVE_FRAMES) ? ENTER_FRAMES : LEAVE_FRAMES;
  localparam int unsigned CW = cnt_w(MAXF);

  logic          down_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  phase_t        ph;

  always_comb begin
    if (down_q) ph = run ? PH_LEAVE : PH_DOWN;
    else        ph = run ? PH_RUN : PH_ENTER;
  end

  assign last = (ph == PH_LEAVE) ? CW'(LEAVE_FRAMES - 1) : CW'(ENTER_FRAMES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      down_q <= 1'b1;
      cnt_q  <= '0;
    end else if (ph == PH_RUN || ph == PH_DOWN) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == last) begin
        down_q <= ~down_q;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign int_rst = down_q;

  // R2: reset is entered only while the run bit is low
  assert_enter_on_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(down_q) |-> $past(!run));
  // R3: reset is left only while the run bit is high
  assert_leave_on_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(down_q) |-> $past(run));
  // R9: the internal reset moves only on a frame strobe
  assert_move_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(down_q) |-> $past(tick));
  // R8: the counter never passes the active limit
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAXF - 1));
endmodule

// File: rtl/crs_init_timer.sv
module crs_init_timer
  import codec_rst_pkg::*;
#(
  parameter int unsigned INIT_FRAMES = 516
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic int_rst,
  output logic busy
);
  localparam int unsigned CW = cnt_w(INIT_FRAMES);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (int_rst) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q && tick) begin
      if (cnt_q == CW'(INIT_FRAMES - 1)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy = busy_q;

  // R5: initialisation ends only on a frame outside reset
  assert_init_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(tick && !int_rst));
  // R11: entering reset abandons any progress
  assert_init_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst |=> (busy_q && cnt_q == '0));
endmodule

// File: rtl/crs_flag_timer.sv
module crs_flag_timer
  import codec_rst_pkg::*;
#(
  parameter int unsigned FLAG_FRAMES = 7,
  parameter int unsigned NFLAG       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  output logic [NFLAG-1:0] zflag
);
  localparam int unsigned CW = cnt_w(FLAG_FRAMES);

  logic          zf_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zf_q  <= 1'b1;
      cnt_q <= '0;
    end else if (!run) begin
      zf_q  <= 1'b1;
      cnt_q <= '0;
    end else if (zf_q && tick) begin
      if (cnt_q == CW'(FLAG_FRAMES - 1)) begin
        zf_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign zflag[i] = zf_q;
  end

  // R6: a low run bit raises the flags on the next clock
  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> zf_q);
  // R7: the flags fall only on a frame with the run bit high
  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(zf_q) |-> $past(run && tick));
endmodule

// File: rtl/codec_rst_seq.sv
module codec_rst_seq
  import codec_rst_pkg::*;
#(
  parameter int unsigned ENTER_FRAMES = 5,
  parameter int unsigned LEAVE_FRAMES = 2,
  parameter int unsigned FLAG_FRAMES  = 7,
  parameter int unsigned INIT_FRAMES  = 516,
  parameter int unsigned NFLAG        = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic             run_req,
  output logic             int_rst,
  output logic             adc_en,
  output logic             dac_en,
  output logic             sdo_force_low,
  output logic             adc_zero,
  output logic [NFLAG-1:0] zflag,
  output logic             ready
);
  logic down;
  logic init_busy;

  crs_reset_delay #(
    .ENTER_FRAMES(ENTER_FRAMES),
    .LEAVE_FRAMES(LEAVE_FRAMES)
  ) u_delay (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (frame_tick),
    .run    (run_req),
    .int_rst(down)
  );

  crs_init_timer #(
    .INIT_FRAMES(INIT_FRAMES)
  ) u_init (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (frame_tick),
    .int_rst(down),
    .busy   (init_busy)
  );

  crs_flag_timer #(
    .FLAG_FRAMES(FLAG_FRAMES),
    .NFLAG      (NFLAG)
  ) u_flag (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (frame_tick),
    .run  (run_req),
    .zflag(zflag)
  );

  assign int_rst       = down;
  assign adc_en        = ~down;
  assign dac_en        = ~down;
  assign sdo_force_low = down;
  assign adc_zero      = down | init_busy;
  assign ready         = ~down & ~init_busy;

  // R10: ready implies the converter blocks are running
  assert_ready_running_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (adc_en && dac_en && !sdo_force_low));
  // R4: the serial output is released only with the blocks enabled
  assert_sdo_vs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_force_low != adc_en) && (adc_en == dac_en));
endmodule

// File: tb/sim_codec_rst_seq.sv
`timescale 1ns/1ps
module sim_codec_rst_seq;
  localparam int NF = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_tick = 1'b0;
  logic          run_req = 1'b1;
  logic          int_rst, adc_en, dac_en, sdo_force_low, adc_zero, ready;
  logic [NF-1:0] zflag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  codec_rst_seq #(.NFLAG(NF)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .run_req(run_req),
    .int_rst(int_rst), .adc_en(adc_en), .dac_en(dac_en),
    .sdo_force_low(sdo_force_low), .adc_zero(adc_zero),
    .zflag(zflag), .ready(ready)
  );

  // vector: run, tick count, expected int_rst, zflag, adc_zero, ready
  localparam int NV = 11;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 10'd1,   4'b1110},
    {1'b1, 10'd1,   4'b0110},
    {1'b1, 10'd4,   4'b0110},
    {1'b1, 10'd1,   4'b0010},
    {1'b1, 10'd510, 4'b0010},
    {1'b1, 10'd1,   4'b0001},
    {1'b0, 10'd0,   4'b0101},
    {1'b0, 10'd4,   4'b0101},
    {1'b0, 10'd1,   4'b1110},
    {1'b1, 10'd1,   4'b1110},
    {1'b1, 10'd1,   4'b0110}
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) frame_tick = 1'b1;
      @(negedge clk) frame_tick = 1'b0;
    end
  endtask

  task automatic set_run(input logic v);
    @(negedge clk) run_req = v;
    @(negedge clk);
  endtask

  task automatic chk_all(input string req, input logic e_rst, input logic e_zf,
                         input logic e_zero, input logic e_rdy);
    chk(req, "int_rst", int_rst, e_rst);
    chk("R4", "adc_en", adc_en, ~e_rst);
    chk("R4", "dac_en", dac_en, ~e_rst);
    chk("R4", "sdo_force_low", sdo_force_low, e_rst);
    chk(req, "zflag", &zflag & |zflag, e_zf);
    chk(req, "zflag_lo", |zflag, e_zf);
    chk("R5", "adc_zero", adc_zero, e_zero);
    chk("R10", "ready", ready, e_rdy);
  endtask

  task automatic hw_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk_all("R1", 1'b1, 1'b1, 1'b1, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1", 1'b1, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1", 1'b1, 1'b1, 1'b1, 1'b0);
    rst_n = 1'b1;

    // table walk: release (R3), flags (R7), init (R5), entry (R2), flags up (R6)
    for (int v = 0; v < NV; v++) begin
      set_run(VEC[v][14]);
      ticks(int'(VEC[v][13:4]));
      chk_all((v < 2) ? "R3" : (v < 4) ? "R7" : (v < 6) ? "R5" : (v < 8) ? "R6" : "R2",
              VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0]);
    end

    // R1: hardware reset mid-run
    hw_reset();

    // R8: cancelled release then full recount
    set_run(1'b1);
    ticks(1);
    set_run(1'b0);
    set_run(1'b1);
    ticks(1);
    chk("R8", "release cancel", int_rst, 1'b1);
    ticks(1);
    chk("R8", "release after recount", int_rst, 1'b0);

    // R8: cancelled entry then full recount
    set_run(1'b0);
    ticks(3);
    set_run(1'b1);
    chk("R8", "entry cancel", int_rst, 1'b0);
    set_run(1'b0);
    ticks(4);
    chk("R8", "entry not early", int_rst, 1'b0);
    ticks(1);
    chk("R8", "entry after recount", int_rst, 1'b1);

    // R11: abort initialisation part way, then full count again
    set_run(1'b1);
    ticks(2);
    chk("R11", "released", int_rst, 1'b0);
    ticks(100);
    chk("R11", "init running", adc_zero, 1'b1);
    set_run(1'b0);
    ticks(5);
    chk("R11", "re-entered", int_rst, 1'b1);
    set_run(1'b1);
    ticks(2);
    ticks(515);
    chk("R11", "init restarted", adc_zero, 1'b1);
    chk("R10", "not ready", ready, 1'b0);
    ticks(1);
    chk("R11", "init done", adc_zero, 1'b0);
    chk("R10", "ready", ready, 1'b1);

    // R9: frames stopped while down
    set_run(1'b0);
    ticks(5);
    set_run(1'b1);
    repeat (300) @(negedge clk);
    chk("R9", "held in reset", int_rst, 1'b1);
    chk("R9", "flags held", zflag[0], 1'b1);
    ticks(2);
    chk("R9", "leaves once framed", int_rst, 1'b0);

    finish_run();
  end
endmodule